// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder and Program Counter

This block is the control section of a 16-bit processor that completes one instruction per clock. It holds the program counter and presents it as the instruction fetch address. The instruction word that comes back is decoded combinationally into the signals the datapath and data memory need for that same cycle. These are three register selects, a 4-bit function code, the selects for the B-operand and write-back multiplexers, the register-file and memory write enables, and three program-counter controls. The block also produces a zero-filled 3-bit immediate constant.

The opcode bits are assigned so that each control signal comes from one or two instruction bits. Bit 9 serves two purposes: it is the low function-code bit, and during branches it picks the branch condition. For that reason the low function-code bit is forced to zero whenever the program counter is loaded. On each rising edge the next PC is chosen from one of three sources: PC plus one, a jump target taken from the Bus A value, or PC plus a sign-extended 6-bit offset. The branch form is taken only when the selected negative or zero status flag is set.

Top module: `scu_ctrl_top`

## Requirements
- R1: While `rst_n` is low the program counter, and with it `imem_addr_o`, is 0, whatever the instruction and status inputs are.
- R2: `dst_sel_o` equals `instr_i[8:6]`, `srca_sel_o` equals `instr_i[5:3]` and `srcb_sel_o` equals `instr_i[2:0]`.
- R3: `const_o` is `instr_i[2:0]` zero-extended to the data width, so its value lies between 0 and 7.
- R4: `func_sel_o` equals `instr_i[12:9]` when `instr_i[15]` and `instr_i[14]` are not both 1; otherwise it is `{instr_i[12:10], 1'b0}`.
- R5: `bsel_const_o` = `instr_i[15]`, `dsel_mem_o` = `instr_i[13]`, `reg_wr_o` = NOT `instr_i[14]`, `mem_wr_o` = NOT `instr_i[15]` AND `instr_i[14]`.
- R6: `pc_load_o` = `instr_i[15]` AND `instr_i[14]`, `jump_o` = `instr_i[13]`, `cond_neg_o` = `instr_i[9]`.
- R7: When `pc_load_o` is 0 the PC advances by one on each rising edge.
- R8: When `pc_load_o` and `jump_o` are both 1 the PC takes the value of `bus_a_i` on the rising edge.
- R9: When `pc_load_o` is 1 and `jump_o` is 0, the condition is `neg_i` if `cond_neg_o` is 1 and `zero_i` otherwise. A true condition adds the two's-complement offset `{instr_i[8:6], instr_i[2:0]}`, sign-extended, to the PC (PC 45 with offset 110100 gives 33). A false condition advances the PC by one.
- R10: PC arithmetic wraps modulo 2^16: advancing from 0xFFFF yields 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 16 | Instruction word fetched at `imem_addr_o` |
| bus_a_i | input | 16 | Value of the A-source register, used as jump target |
| neg_i | input | 1 | Negative status from the function unit |
| zero_i | input | 1 | Zero status from the function unit |
| imem_addr_o | output | 16 | Program counter, instruction fetch address |
| dst_sel_o | output | 3 | Destination register select |
| srca_sel_o | output | 3 | A-source register select |
| srcb_sel_o | output | 3 | B-source register select |
| const_o | output | 16 | Zero-filled immediate constant |
| func_sel_o | output | 4 | Function unit operation code |
| bsel_const_o | output | 1 | B operand multiplexer picks the constant |
| dsel_mem_o | output | 1 | Write-back multiplexer picks memory data |
| reg_wr_o | output | 1 | Register file write enable |
| mem_wr_o | output | 1 | Data memory write enable |
| pc_load_o | output | 1 | PC is loaded this cycle (jump or branch) |
| jump_o | output | 1 | Jump rather than conditional branch |
| cond_neg_o | output | 1 | Branch tests negative flag (1) or zero flag (0) |

## Verification
Four properties are checked on every clock. In the sequential path, a PC with no load advances by one, and a jump lands on the Bus A value. A branch either adds its offset or falls through, depending on the flag it selects. In the decoder, a loaded PC never carries a set low function bit. The bench scenarios cover the rest. They show the field pass-through and the single-bit control mapping across register, immediate, load, store, jump and branch opcodes. They also show that reset holds the PC at zero while a jump is presented, that the offset sign is handled with the -12 example, and that the PC wraps from 0xFFFF to zero.

// File: rtl/scu_pkg.sv
package scu_pkg;

    localparam int INSTR_W = 16;
    localparam int SEL_W   = 3;
    localparam int FUNC_W  = 4;
    localparam int OFF_W   = 2 * SEL_W;

    // bit positions that the control mapping depends on
    localparam int B_BCONST = 15;
    localparam int B_LDSEL  = 14;
    localparam int B_DMEM   = 13;
    localparam int B_FLO    = 9;
    localparam int B_FHI    = 12;
    localparam int B_DHI    = 8;
    localparam int B_DLO    = 6;
    localparam int B_AHI    = 5;
    localparam int B_ALO    = 3;
    localparam int B_BHI    = 2;

    typedef struct packed {
        logic [SEL_W-1:0]  dst;
        logic [SEL_W-1:0]  srca;
        logic [SEL_W-1:0]  srcb;
        logic [FUNC_W-1:0] func;
        logic              bsel_const;
        logic              dsel_mem;
        logic              reg_wr;
        logic              mem_wr;
        logic              pc_load;
        logic              jump;
        logic              cond_neg;
    } ctrl_t;

endpackage

// File: rtl/scu_decode.sv
module scu_decode
    import scu_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl,
    output logic [XLEN-1:0]    konst,
    output logic [OFF_W-1:0]   offset
);

    localparam int PAD_W = XLEN - SEL_W;

    logic load_pc;

    always_comb begin
        load_pc          = instr[B_BCONST] & instr[B_LDSEL];
        ctrl.dst         = instr[B_DHI:B_DLO];
        ctrl.srca        = instr[B_AHI:B_ALO];
        ctrl.srcb        = instr[B_BHI:0];
        ctrl.func        = {instr[B_FHI:B_FLO+1], instr[B_FLO] & ~load_pc};
        ctrl.bsel_const  = instr[B_BCONST];
        ctrl.dsel_mem    = instr[B_DMEM];
        ctrl.reg_wr      = ~instr[B_LDSEL];
        ctrl.mem_wr      = ~instr[B_BCONST] & instr[B_LDSEL];
        ctrl.pc_load     = load_pc;
        ctrl.jump        = instr[B_DMEM];
        ctrl.cond_neg    = instr[B_FLO];
        konst            = {{PAD_W{1'b0}}, instr[B_BHI:0]};
        offset           = {instr[B_DHI:B_DLO], instr[B_BHI:0]};
    end

    // a PC-loading instruction must present an even function code
    AST_BRANCH_FUNC_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.pc_load |-> !ctrl.func[0]); // R4

endmodule

// File: rtl/scu_next_pc.sv
module scu_next_pc
    import scu_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic [XLEN-1:0]  pc,
    input  ctrl_t            ctrl,
    input  logic [OFF_W-1:0] offset,
    input  logic [XLEN-1:0]  bus_a,
    input  logic             neg,
    input  logic             zero,
    output logic [XLEN-1:0]  pc_next
);

    localparam int EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] pc_rel;
    logic            cond;

    always_comb begin
        pc_inc = pc + XLEN'(1);
        pc_rel = pc + {{EXT_W{offset[OFF_W-1]}}, offset};
        cond   = ctrl.cond_neg ? neg : zero;
        if (!ctrl.pc_load) begin
            pc_next = pc_inc;
        end else if (ctrl.jump) begin
            pc_next = bus_a;
        end else if (cond) begin
            pc_next = pc_rel;
        end else begin
            pc_next = pc_inc;
        end
    end

endmodule

// File: rtl/scu_ctrl_top.sv
module scu_ctrl_top
    import scu_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [XLEN-1:0]    bus_a_i,
    input  logic               neg_i,
    input  logic               zero_i,
    output logic [XLEN-1:0]    imem_addr_o,
    output logic [SEL_W-1:0]   dst_sel_o,
    output logic [SEL_W-1:0]   srca_sel_o,
    output logic [SEL_W-1:0]   srcb_sel_o,
    output logic [XLEN-1:0]    const_o,
    output logic [FUNC_W-1:0]  func_sel_o,
    output logic               bsel_const_o,
    output logic               dsel_mem_o,
    output logic               reg_wr_o,
    output logic               mem_wr_o,
    output logic               pc_load_o,
    output logic               jump_o,
    output logic               cond_neg_o
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    ctrl_t            ctrl;
    logic [OFF_W-1:0] offset;
    logic [XLEN-1:0]  pc_next;

    scu_decode #(.XLEN(XLEN)) u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .instr  (instr_i),
        .ctrl   (ctrl),
        .konst  (const_o),
        .offset (offset)
    );

    scu_next_pc #(.XLEN(XLEN)) u_next_pc (
        .pc      (st_q.pc),
        .ctrl    (ctrl),
        .offset  (offset),
        .bus_a   (bus_a_i),
        .neg     (neg_i),
        .zero    (zero_i),
        .pc_next (pc_next)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr_o  = st_q.pc;
    assign dst_sel_o    = ctrl.dst;
    assign srca_sel_o   = ctrl.srca;
    assign srcb_sel_o   = ctrl.srcb;
    assign func_sel_o   = ctrl.func;
    assign bsel_const_o = ctrl.bsel_const;
    assign dsel_mem_o   = ctrl.dsel_mem;
    assign reg_wr_o     = ctrl.reg_wr;
    assign mem_wr_o     = ctrl.mem_wr;
    assign pc_load_o    = ctrl.pc_load;
    assign jump_o       = ctrl.jump;
    assign cond_neg_o   = ctrl.cond_neg;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_load_o |=> imem_addr_o == $past(imem_addr_o) + XLEN'(1)); // R7

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && jump_o) |=> imem_addr_o == $past(bus_a_i)); // R8

    AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && !jump_o && (cond_neg_o ? neg_i : zero_i))
        |=> imem_addr_o == $past(imem_addr_o)
            + {{(XLEN-OFF_W){$past(instr_i[B_DHI])}},
               $past(instr_i[B_DHI:B_DLO]), $past(instr_i[B_BHI:0])}); // R9

    AST_BRANCH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load_o && !jump_o && !(cond_neg_o ? neg_i : zero_i))
        |=> imem_addr_o == $past(imem_addr_o) + XLEN'(1)); // R9

endmodule

// File: tb/scu_ctrl_top_test.sv
module scu_ctrl_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] bus_a = '0;
    logic        neg = 1'b0;
    logic        zero = 1'b0;

    logic [15:0] addr;
    logic [2:0]  dsel, asel, bsel;
    logic [15:0] kon;
    logic [3:0]  func;
    logic        bconst, dmem, rwr, mwr, pload, jmp, cneg;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [2:0]  dsel, asel, bsel;
        logic [15:0] kon;
        logic [3:0]  func;
        logic [6:0]  ctl;
        logic [15:0] pc;
    } exp_t;

    exp_t q[$];
    logic [15:0] pc_m = '0;

    always #10 clk = ~clk; // 50 MHz

    scu_ctrl_top uut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .bus_a_i(bus_a),
        .neg_i(neg), .zero_i(zero), .imem_addr_o(addr),
        .dst_sel_o(dsel), .srca_sel_o(asel), .srcb_sel_o(bsel),
        .const_o(kon), .func_sel_o(func), .bsel_const_o(bconst),
        .dsel_mem_o(dmem), .reg_wr_o(rwr), .mem_wr_o(mwr),
        .pc_load_o(pload), .jump_o(jmp), .cond_neg_o(cneg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [6:0] opc, input logic [2:0] f1,
                                       input logic [2:0] f2, input logic [2:0] f3);
        return {opc, f1, f2, f3};
    endfunction

    // apply one instruction at a falling edge and queue what must follow
    task automatic step(input logic [15:0] ir, input logic [15:0] a,
                        input logic n, input logic z);
        exp_t e;
        logic ld;
        logic c;
        logic [15:0] off;
        instr = ir; bus_a = a; neg = n; zero = z;
        ld = ir[15] & ir[14];
        e.dsel = ir[8:6];                                     // R2
        e.asel = ir[5:3];
        e.bsel = ir[2:0];
        e.kon  = {13'd0, ir[2:0]};                            // R3
        e.func = ld ? {ir[12:10], 1'b0} : ir[12:9];           // R4
        e.ctl  = {ir[15], ir[13], ~ir[14], ~ir[15] & ir[14],  // R5
                  ld, ir[13], ir[9]};                         // R6
        off    = {{10{ir[8]}}, ir[8:6], ir[2:0]};
        c      = ir[9] ? n : z;
        if (!ld) pc_m = pc_m + 16'd1;                         // R7, R10
        else if (ir[13]) pc_m = a;                            // R8
        else if (c) pc_m = pc_m + off;                        // R9
        else pc_m = pc_m + 16'd1;
        e.pc = pc_m;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: after each rising edge compare decode and the new PC
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R2 dst",  32'(dsel), 32'(e.dsel));
                chk("R2 srca", 32'(asel), 32'(e.asel));
                chk("R2 srcb", 32'(bsel), 32'(e.bsel));
                chk("R3 const", 32'(kon), 32'(e.kon));
                chk("R4 func", 32'(func), 32'(e.func));
                chk("R5 R6 ctl", 32'({bconst, dmem, rwr, mwr, pload, jmp, cneg}), 32'(e.ctl));
                chk("R7 R8 R9 R10 pc", 32'(addr), 32'(e.pc));
            end
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog R1-R10 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        instr = mk(7'b1110000, 3'd0, 3'd1, 3'd0); // jump held during reset
        bus_a = 16'h1234;
        repeat (3) @(negedge clk);
        chk("R1 reset pc", 32'(addr), 32'h0);
        @(negedge clk);
        chk("R1 reset pc held", 32'(addr), 32'h0);
        rst_n = 1'b1;
        pc_m  = '0;
        step(mk(7'b0000010, 3'd1, 3'd2, 3'd3), 16'h0, 1'b0, 1'b0); // register add
        step(mk(7'b1000010, 3'd4, 3'd7, 3'd5), 16'h0, 1'b0, 1'b0); // immediate add
        step(mk(7'b0010000, 3'd6, 3'd2, 3'd0), 16'h0, 1'b0, 1'b0); // memory load
        step(mk(7'b0100000, 3'd0, 3'd4, 3'd5), 16'h0, 1'b1, 1'b1); // memory store
        step(mk(7'b0001111, 3'd7, 3'd7, 3'd7), 16'h0, 1'b0, 1'b0); // odd func, no load
        step(mk(7'b1110000, 3'd0, 3'd3, 3'd0), 16'd45, 1'b0, 1'b0); // jump to 45
        step(mk(7'b1100000, 3'b110, 3'd6, 3'b100), 16'h0, 1'b0, 1'b1); // R9 45-12=33
        step(mk(7'b1100001, 3'b110, 3'd6, 3'b100), 16'h0, 1'b0, 1'b1); // neg cond false
        step(mk(7'b1100001, 3'b000, 3'd2, 3'b011), 16'h0, 1'b1, 1'b0); // neg taken +3
        step(mk(7'b1100000, 3'b011, 3'd2, 3'b111), 16'h0, 1'b1, 1'b0); // zero false
        step(mk(7'b1101111, 3'd1, 3'd1, 3'd1), 16'h0, 1'b0, 1'b1);  // R4 func forced even
        step(mk(7'b1110001, 3'd2, 3'd5, 3'd1), 16'hFFFF, 1'b1, 1'b1); // jump to top
        step(mk(7'b0000101, 3'd3, 3'd1, 3'd2), 16'h0, 1'b0, 1'b0); // R10 wrap to 0
        step(mk(7'b1100000, 3'b111, 3'd0, 3'b111), 16'h0, 1'b0, 1'b1); // -1 wraps
        step(mk(7'b1000000, 3'd0, 3'd0, 3'd0), 16'h0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R1-R10 queue drained", 32'(q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule